// File: doc/BRIEF.md
# Single-Register ALU and Status Unit

This unit executes the one-operand register instructions of a 16-bit processor with eight general registers and four status flags: sign (S), zero (Z), overflow (O) and carry (C). It covers increment, decrement, one's and two's complement, add-carry, packing the flags into a register, restoring the flags from a register, byte swap, logical left shift and rotate left through carry. It also covers the flag-control instructions that set or clear carry, enable or disable interrupts, and arm the double-byte-data prefix. Memory-access and branch instructions are outside its scope and are reported as illegal.

A 10-bit opcode enters on a valid/ready handshake. `op_ready` is high only while the unit is idle. An opcode is taken on a clock edge where `op_valid` and `op_ready` are both high. The sender must hold `opcode` stable with `op_valid` high until that edge. In the cycle after acceptance the unit drives the register-file read address, takes the operand combinationally from `rf_rdata`, and raises `done` for exactly one cycle. During that cycle it drives the register write port and the cycle cost of the instruction. The flag outputs take their new values at the edge that ends the `done` cycle. With a sender that always has work, the unit accepts one opcode every two clock cycles.

Top module: `regop_unit`

## Requirements
- R1: After reset `op_ready` is 1, `done` is 0, and the S, Z, O, C, interrupt-enable and double-byte flags are all 0. An accepted opcode gives a `done` pulse of exactly one cycle on the following cycle, and `op_ready` is 0 during that cycle.
- R2: Opcodes 0x008-0x00F (increment), 0x010-0x017 (decrement) and 0x018-0x01F (complement) take their register from opcode bits 2:0. They write the result back, set S from result bit 15 and Z when the 16-bit result is zero, leave O and C unchanged, and cost 6 cycles.
- R3: Opcodes 0x020-0x027 (bits 2:0 select the register) write the two's complement (inverted operand plus one). C is bit 16 of that sum, so it is set only for operand 0. O is signed overflow of that sum, so it is set only for 0x8000. S and Z are set from the result. The cost is 6 cycles.
- R4: Opcodes 0x028-0x02F (bits 2:0 select the register) write the operand plus C. C becomes bit 16 of the sum, O becomes signed overflow, and S and Z are set from the result. The cost is 6 cycles.
- R5: Opcodes 0x030-0x033 take their register from bits 1:0. They write the nibble {S,Z,O,C} (S the MSB) into bits 15:12 and into bits 7:4, with all other bits zero. Flags are unchanged and the cost is 6 cycles.
- R6: Opcodes 0x038-0x03F (bits 2:0 select the register) load C from bit 7, O from bit 6, Z from bit 5 and S from bit 4 of the register. They write nothing and cost 6 cycles.
- R7: Opcodes 0x040-0x047 (swap) take their register from bits 1:0. Bit 2 = 0 exchanges the two bytes at a cost of 6 cycles. Bit 2 = 1 copies the low byte into both bytes at a cost of 8 cycles. S comes from result bit 7, Z comes from the 16-bit result, and O and C are unchanged.
- R8: Opcodes 0x048-0x04F (left shift) take their register from bits 1:0 and shift in zeros: by one place when bit 2 = 0 (6 cycles) and by two places when bit 2 = 1 (8 cycles). S comes from bit 15, Z is set on a zero result, and O and C are unchanged.
- R9: Opcodes 0x050-0x057 (rotate through carry) take their register from bits 1:0. The single form (bit 2 = 0, 6 cycles) shifts left once, inserts the old C at bit 0 and sets C from the old bit 15. The double form (bit 2 = 1, 8 cycles) shifts left twice, inserts the old C at bit 1 and the old O at bit 0, sets C from the old bit 15 and sets O from the old bit 14. S and Z are set from the result.
- R10: The flag-control opcodes cost 4 cycles and write no register: 0x006 clears C, 0x007 sets C, 0x002 sets interrupt enable, 0x003 clears it, and 0x001 sets the double-byte flag.
- R11: The double-byte flag stays set until the next completed opcode that is not 0x001, which clears it. Opcodes 0x034 and 0x035 write nothing, change no other flag and cost 6 cycles.
- R12: Opcode 0x000 and every opcode not listed above (including 0x004, 0x005, 0x036, 0x037 and all opcodes from 0x058 up) complete with `illegal` = 1 and a cost of 0. They write no register and change no flag other than clearing the double-byte flag.
- R13: `rf_we` is high only during a `done` cycle, and the flag outputs change only at the edge that ends a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode offered |
| op_ready | output | 1 | Unit idle, opcode can be taken |
| opcode | input | 10 | Instruction word |
| rf_raddr | output | 3 | Register-file read index |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| done_cycles | output | 4 | Cycle cost of the completing instruction |
| illegal | output | 1 | Completing opcode is not executed |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_o | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| intr_en | output | 1 | Interrupt-enable flag |
| dbl_data | output | 1 | Double-byte-data prefix flag |

## Verification
The hardest results to reach are those that depend on the incoming flag values: the add-carry and double rotate results and the flags left unchanged by the shift group. The unit has no direct flag-load port, so before each table vector the bench runs a flag-restore opcode on a spare register. That register holds the wanted S, Z, O, C pattern in bits 7:4, which puts the flags into a known state. The bench then preloads the target register and issues the opcode under test. The back-pressure case holds `op_valid` high through a `done` cycle and checks that the second opcode waits and is then executed.

// File: rtl/regop_pkg.sv
package regop_pkg;
  localparam int DW    = 16;
  localparam int HW    = DW / 2;
  localparam int OPC_W = 10;
  localparam int RA_W  = 3;
  localparam int CYC_W = 4;

  typedef enum logic [4:0] {
    K_ILL, K_INC, K_DEC, K_COM, K_NEG, K_ADC, K_GSW, K_RSW,
    K_SWP, K_SLL, K_RLC, K_NOP, K_CLRC, K_SETC, K_EIS, K_DIS, K_SDBD
  } op_kind_e;

  typedef struct packed {
    logic s;
    logic z;
    logic o;
    logic c;
  } flags_t;

  typedef struct packed {
    op_kind_e              kind;
    logic [RA_W-1:0]       ridx;
    logic                  dbl;
    logic                  wr;
    logic [CYC_W-1:0]      cyc;
  } dec_t;
endpackage

// File: rtl/regop_decode.sv
module regop_decode
  import regop_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);
  localparam logic [CYC_W-1:0] CYC_CTL = CYC_W'(4);
  localparam logic [CYC_W-1:0] CYC_REG = CYC_W'(6);
  localparam logic [CYC_W-1:0] CYC_DBL = CYC_W'(8);

  logic [RA_W-1:0] r_wide;
  logic [RA_W-1:0] r_narrow;

  assign r_wide   = opcode[RA_W-1:0];
  assign r_narrow = {1'b0, opcode[1:0]};

  always_comb begin
    dec.kind = K_ILL;
    dec.ridx = r_wide;
    dec.dbl  = 1'b0;
    dec.wr   = 1'b0;
    dec.cyc  = '0;
    if (opcode[OPC_W-1:7] == '0) begin
      case (opcode[6:3])
        4'h0: begin
          dec.cyc = CYC_CTL;
          case (opcode[2:0])
            3'd1:    dec.kind = K_SDBD;
            3'd2:    dec.kind = K_EIS;
            3'd3:    dec.kind = K_DIS;
            3'd6:    dec.kind = K_CLRC;
            3'd7:    dec.kind = K_SETC;
            default: begin
              dec.kind = K_ILL;
              dec.cyc  = '0;
            end
          endcase
        end
        4'h1: begin dec.kind = K_INC; dec.wr = 1'b1; dec.cyc = CYC_REG; end
        4'h2: begin dec.kind = K_DEC; dec.wr = 1'b1; dec.cyc = CYC_REG; end
        4'h3: begin dec.kind = K_COM; dec.wr = 1'b1; dec.cyc = CYC_REG; end
        4'h4: begin dec.kind = K_NEG; dec.wr = 1'b1; dec.cyc = CYC_REG; end
        4'h5: begin dec.kind = K_ADC; dec.wr = 1'b1; dec.cyc = CYC_REG; end
        4'h6: begin
          if (!opcode[2]) begin
            dec.kind = K_GSW;
            dec.ridx = r_narrow;
            dec.wr   = 1'b1;
            dec.cyc  = CYC_REG;
          end else if (!opcode[1]) begin
            dec.kind = K_NOP;
            dec.cyc  = CYC_REG;
          end
        end
        4'h7: begin dec.kind = K_RSW; dec.cyc = CYC_REG; end
        4'h8, 4'h9, 4'hA: begin
          dec.kind = (opcode[6:3] == 4'h8) ? K_SWP :
                     (opcode[6:3] == 4'h9) ? K_SLL : K_RLC;
          dec.ridx = r_narrow;
          dec.dbl  = opcode[2];
          dec.wr   = 1'b1;
          dec.cyc  = opcode[2] ? CYC_DBL : CYC_REG;
        end
        default: dec.kind = K_ILL;
      endcase
    end
  end
endmodule

// File: rtl/regop_datapath.sv
module regop_datapath
  import regop_pkg::*;
(
  input  op_kind_e        kind,
  input  logic            dbl,
  input  logic [DW-1:0]   operand,
  input  flags_t          fin,
  output logic [DW-1:0]   result,
  output flags_t          fout
);
  logic [DW-1:0] add_a;
  logic [DW-1:0] add_b;
  logic [DW:0]   sum;
  logic          add_ovf;
  logic [DW-1:0] swp_res;
  logic [3:0]    nib;

  assign add_a   = (kind == K_NEG) ? ~operand : operand;
  assign add_b   = (kind == K_NEG) ? DW'(1) : DW'(fin.c);
  assign sum     = {1'b0, add_a} + {1'b0, add_b};
  assign add_ovf = (add_a[DW-1] == add_b[DW-1]) && (sum[DW-1] != add_a[DW-1]);
  assign nib     = {fin.s, fin.z, fin.o, fin.c};

  generate
    if (DW % 2 == 0) begin : g_swap
      assign swp_res = dbl ? {operand[HW-1:0], operand[HW-1:0]}
                           : {operand[HW-1:0], operand[DW-1:HW]};
    end else begin : g_swap_odd
      assign swp_res = operand;
    end
  endgenerate

  always_comb begin
    result = operand;
    fout   = fin;
    case (kind)
      K_INC: result = operand + DW'(1);
      K_DEC: result = operand - DW'(1);
      K_COM: result = ~operand;
      K_NEG, K_ADC: begin
        result = sum[DW-1:0];
        fout.c = sum[DW];
        fout.o = add_ovf;
      end
      K_GSW: begin
        result = '0;
        result[DW-1 -: 4] = nib;
        result[HW-1 -: 4] = nib;
      end
      K_RSW: begin
        fout.c = operand[HW-1];
        fout.o = operand[HW-2];
        fout.z = operand[HW-3];
        fout.s = operand[HW-4];
      end
      K_SWP: result = swp_res;
      K_SLL: result = dbl ? {operand[DW-3:0], 2'b00} : {operand[DW-2:0], 1'b0};
      K_RLC: begin
        fout.c = operand[DW-1];
        if (dbl) begin
          result = {operand[DW-3:0], fin.c, fin.o};
          fout.o = operand[DW-2];
        end else begin
          result = {operand[DW-2:0], fin.c};
        end
      end
      K_CLRC: fout.c = 1'b0;
      K_SETC: fout.c = 1'b1;
      default: result = operand;
    endcase
    case (kind)
      K_INC, K_DEC, K_COM, K_NEG, K_ADC, K_SLL, K_RLC: begin
        fout.s = result[DW-1];
        fout.z = (result == '0);
      end
      K_SWP: begin
        fout.s = result[HW-1];
        fout.z = (result == '0);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regop_unit.sv
module regop_unit
  import regop_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [OPC_W-1:0] opcode,
  output logic [RA_W-1:0]  rf_raddr,
  input  logic [DW-1:0]    rf_rdata,
  output logic             rf_we,
  output logic [RA_W-1:0]  rf_waddr,
  output logic [DW-1:0]    rf_wdata,
  output logic             done,
  output logic [CYC_W-1:0] done_cycles,
  output logic             illegal,
  output logic             flag_s,
  output logic             flag_z,
  output logic             flag_o,
  output logic             flag_c,
  output logic             intr_en,
  output logic             dbl_data
);
  logic             busy_q;
  logic [OPC_W-1:0] op_q;
  flags_t           flg_q;
  flags_t           flg_nx;
  logic             intr_q;
  logic             dbl_q;
  dec_t             dec;
  logic [DW-1:0]    res;

  regop_decode u_dec (
    .opcode (op_q),
    .dec    (dec)
  );

  regop_datapath u_dp (
    .kind    (dec.kind),
    .dbl     (dec.dbl),
    .operand (rf_rdata),
    .fin     (flg_q),
    .result  (res),
    .fout    (flg_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      flg_q  <= '0;
      intr_q <= 1'b0;
      dbl_q  <= 1'b0;
    end else if (busy_q) begin
      busy_q <= 1'b0;
      flg_q  <= flg_nx;
      dbl_q  <= (dec.kind == K_SDBD);
      if (dec.kind == K_EIS) intr_q <= 1'b1;
      if (dec.kind == K_DIS) intr_q <= 1'b0;
    end else if (op_valid) begin
      busy_q <= 1'b1;
      op_q   <= opcode;
    end
  end

  assign op_ready    = !busy_q;
  assign done        = busy_q;
  assign rf_raddr    = dec.ridx;
  assign rf_waddr    = dec.ridx;
  assign rf_wdata    = res;
  assign rf_we       = busy_q && dec.wr;
  assign done_cycles = busy_q ? dec.cyc : '0;
  assign illegal     = busy_q && (dec.kind == K_ILL);
  assign flag_s      = flg_q.s;
  assign flag_z      = flg_q.z;
  assign flag_o      = flg_q.o;
  assign flag_c      = flg_q.c;
  assign intr_en     = intr_q;
  assign dbl_data    = dbl_q;
endmodule

// File: rtl/regop_unit_chk.sv
module regop_unit_chk
  import regop_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic             done,
  input logic             rf_we,
  input logic [CYC_W-1:0] done_cycles,
  input logic             illegal,
  input logic [3:0]       flags,
  input logic             intr_en,
  input logic             dbl_data
);
  // R1
  a_r1_accept_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> done);
  // R1
  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  a_r1_no_ready_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !op_ready);
  // R13
  a_r13_write_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);
  // R13
  a_r13_flags_move_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({flags, intr_en}) |-> $past(done));
  // R12
  a_r12_illegal_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> (!rf_we && done_cycles == '0));
  // R12
  a_r12_illegal_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |=> ($stable(flags) && $stable(intr_en) && !dbl_data));
  // R10
  a_r10_cost_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> (done_cycles == 4'd4 || done_cycles == 4'd6 || done_cycles == 4'd8));
endmodule

bind regop_unit regop_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_ready    (op_ready),
  .done        (done),
  .rf_we       (rf_we),
  .done_cycles (done_cycles),
  .illegal     (illegal),
  .flags       ({flag_s, flag_z, flag_o, flag_c}),
  .intr_en     (intr_en),
  .dbl_data    (dbl_data)
);

// File: tb/tb_regop_unit.sv
`timescale 1ns/1ps
module tb_regop_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [9:0]  opcode = '0;
  logic [2:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        done;
  logic [3:0]  done_cycles;
  logic        illegal;
  logic        flag_s, flag_z, flag_o, flag_c, intr_en, dbl_data;

  logic [15:0] rf [8];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  regop_unit dut (.*);

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  typedef struct packed {
    logic [9:0]  opc;
    logic [2:0]  ridx;
    logic [15:0] val;
    logic [3:0]  fin;
    logic        we;
    logic [15:0] wd;
    logic [3:0]  fout;
    logic [3:0]  cyc;
    logic        ill;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{10'h009, 3'd1, 16'h7FFF, 4'b0001, 1'b1, 16'h8000, 4'b1001, 4'd6, 1'b0}, // R2 inc
    '{10'h00A, 3'd2, 16'hFFFF, 4'b0010, 1'b1, 16'h0000, 4'b0110, 4'd6, 1'b0}, // R2 inc wrap
    '{10'h010, 3'd0, 16'h0000, 4'b0000, 1'b1, 16'hFFFF, 4'b1000, 4'd6, 1'b0}, // R2 dec
    '{10'h017, 3'd7, 16'h0001, 4'b1000, 1'b1, 16'h0000, 4'b0100, 4'd6, 1'b0}, // R2 dec zero
    '{10'h01B, 3'd3, 16'h00FF, 4'b0000, 1'b1, 16'hFF00, 4'b1000, 4'd6, 1'b0}, // R2 com
    '{10'h01D, 3'd5, 16'hFFFF, 4'b1001, 1'b1, 16'h0000, 4'b0101, 4'd6, 1'b0}, // R2 com zero
    '{10'h024, 3'd4, 16'h0001, 4'b0000, 1'b1, 16'hFFFF, 4'b1000, 4'd6, 1'b0}, // R3
    '{10'h021, 3'd1, 16'h0000, 4'b0000, 1'b1, 16'h0000, 4'b0101, 4'd6, 1'b0}, // R3 carry
    '{10'h022, 3'd2, 16'h8000, 4'b0000, 1'b1, 16'h8000, 4'b1010, 4'd6, 1'b0}, // R3 ovf
    '{10'h02B, 3'd3, 16'h7FFF, 4'b0001, 1'b1, 16'h8000, 4'b1010, 4'd6, 1'b0}, // R4 ovf
    '{10'h028, 3'd0, 16'hFFFF, 4'b0001, 1'b1, 16'h0000, 4'b0101, 4'd6, 1'b0}, // R4 carry
    '{10'h02F, 3'd7, 16'h1234, 4'b0000, 1'b1, 16'h1234, 4'b0000, 4'd6, 1'b0}, // R4 no c
    '{10'h032, 3'd2, 16'hABCD, 4'b1011, 1'b1, 16'hB0B0, 4'b1011, 4'd6, 1'b0}, // R5
    '{10'h030, 3'd0, 16'h5555, 4'b0100, 1'b1, 16'h4040, 4'b0100, 4'd6, 1'b0}, // R5
    '{10'h03D, 3'd5, 16'h00A0, 4'b0000, 1'b0, 16'h0000, 4'b0101, 4'd6, 1'b0}, // R6
    '{10'h03B, 3'd3, 16'hFF50, 4'b0101, 1'b0, 16'h0000, 4'b1010, 4'd6, 1'b0}, // R6
    '{10'h041, 3'd1, 16'h12F0, 4'b1001, 1'b1, 16'hF012, 4'b0001, 4'd6, 1'b0}, // R7 single
    '{10'h046, 3'd2, 16'h3480, 4'b0000, 1'b1, 16'h8080, 4'b1000, 4'd8, 1'b0}, // R7 double
    '{10'h043, 3'd3, 16'h0000, 4'b0000, 1'b1, 16'h0000, 4'b0100, 4'd6, 1'b0}, // R7 zero
    '{10'h048, 3'd0, 16'h4001, 4'b0011, 1'b1, 16'h8002, 4'b1011, 4'd6, 1'b0}, // R8 single
    '{10'h04F, 3'd3, 16'hC000, 4'b0000, 1'b1, 16'h0000, 4'b0100, 4'd8, 1'b0}, // R8 double
    '{10'h051, 3'd1, 16'h8001, 4'b0000, 1'b1, 16'h0002, 4'b0001, 4'd6, 1'b0}, // R9 single
    '{10'h052, 3'd2, 16'h4000, 4'b0001, 1'b1, 16'h8001, 4'b1000, 4'd6, 1'b0}, // R9 single
    '{10'h054, 3'd0, 16'h4000, 4'b0001, 1'b1, 16'h0002, 4'b0010, 4'd8, 1'b0}, // R9 double
    '{10'h057, 3'd3, 16'h8000, 4'b0010, 1'b1, 16'h0001, 4'b0001, 4'd8, 1'b0}, // R9 double
    '{10'h006, 3'd0, 16'h0000, 4'b1111, 1'b0, 16'h0000, 4'b1110, 4'd4, 1'b0}, // R10 clrc
    '{10'h007, 3'd0, 16'h0000, 4'b0000, 1'b0, 16'h0000, 4'b0001, 4'd4, 1'b0}, // R10 setc
    '{10'h034, 3'd0, 16'h0000, 4'b1010, 1'b0, 16'h0000, 4'b1010, 4'd6, 1'b0}, // R11 nop
    '{10'h000, 3'd0, 16'h0000, 4'b0101, 1'b0, 16'h0000, 4'b0101, 4'd0, 1'b1}, // R12 halt
    '{10'h058, 3'd0, 16'h0000, 4'b1100, 1'b0, 16'h0000, 4'b1100, 4'd0, 1'b1}, // R12
    '{10'h004, 3'd0, 16'h0000, 4'b0011, 1'b0, 16'h0000, 4'b0011, 4'd0, 1'b1}  // R12 jump
  };

  logic        o_done, o_rdy, o_we, o_ill, o_done2;
  logic [2:0]  o_wa;
  logic [15:0] o_wd;
  logic [3:0]  o_cyc, o_flags;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [9:0] opc);
    @(negedge clk);
    op_valid = 1'b1;
    opcode   = opc;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    o_done = done; o_rdy = op_ready; o_we = rf_we; o_ill = illegal;
    o_wa = rf_waddr; o_wd = rf_wdata; o_cyc = done_cycles;
    @(posedge clk);
    @(negedge clk);
    o_done2 = done;
    o_flags = {flag_s, flag_z, flag_o, flag_c};
  endtask

  task automatic set_flags(input logic [3:0] f);
    rf[6] = {8'h00, f[0], f[1], f[2], f[3], 4'h0};
    run_op(10'h03E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(op_ready == 1'b1, "R1 reset ready", op_ready, 1);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk({flag_s, flag_z, flag_o, flag_c, intr_en, dbl_data} == 6'b0, "R1 reset flags",
        {flag_s, flag_z, flag_o, flag_c, intr_en, dbl_data}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      set_flags(VEC[v].fin);
      rf[VEC[v].ridx] = VEC[v].val;
      run_op(VEC[v].opc);
      chk(o_done && !o_rdy && !o_done2, $sformatf("R1 pulse v%0d", v), {o_done, o_rdy, o_done2}, 3'b100);
      chk(o_we == VEC[v].we, $sformatf("R13 we v%0d op %0h", v, VEC[v].opc), o_we, VEC[v].we);
      if (VEC[v].we)
        chk(o_wd == VEC[v].wd && o_wa == VEC[v].ridx, $sformatf("result v%0d op %0h", v, VEC[v].opc),
            {o_wa, o_wd}, {VEC[v].ridx, VEC[v].wd});
      chk(o_flags == VEC[v].fout, $sformatf("flags v%0d op %0h", v, VEC[v].opc), o_flags, VEC[v].fout);
      chk(o_cyc == VEC[v].cyc, $sformatf("cycles v%0d op %0h", v, VEC[v].opc), o_cyc, VEC[v].cyc);
      chk(o_ill == VEC[v].ill, $sformatf("R12 illegal v%0d", v), o_ill, VEC[v].ill);
    end

    // R10 interrupt enable and disable
    run_op(10'h002);
    chk(intr_en == 1'b1 && o_cyc == 4'd4 && !o_we, "R10 enable", {intr_en, o_cyc}, 5'h14);
    run_op(10'h003);
    chk(intr_en == 1'b0 && o_cyc == 4'd4, "R10 disable", {intr_en, o_cyc}, 5'h04);

    // R10 R11 double-byte prefix set, then cleared by next op
    run_op(10'h001);
    chk(dbl_data == 1'b1 && o_cyc == 4'd4, "R10 prefix set", {dbl_data, o_cyc}, 5'h14);
    run_op(10'h035);
    chk(dbl_data == 1'b0 && !o_we && o_cyc == 4'd6, "R11 prefix cleared by nop", {dbl_data, o_we, o_cyc}, 6'h06);
    run_op(10'h001);
    run_op(10'h036);
    chk(dbl_data == 1'b0 && o_ill, "R12 prefix cleared by illegal", {dbl_data, o_ill}, 2'b01);

    // R1 back-pressure: two increments offered back to back
    rf[1] = 16'h0010;
    @(negedge clk);
    op_valid = 1'b1;
    opcode   = 10'h009;
    @(posedge clk);
    @(negedge clk);
    chk(done && !op_ready, "R1 busy blocks", {done, op_ready}, 2'b10);
    opcode = 10'h009;
    @(posedge clk);
    @(negedge clk);
    chk(!done && op_ready, "R1 idle between", {done, op_ready}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(done == 1'b1, "R1 second accepted", done, 1);
    @(posedge clk);
    @(negedge clk);
    chk(rf[1] == 16'h0012, "R2 both executed", rf[1], 16'h0012);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule